// File: doc/BRIEF.md
# Clock Output Stop Controller

This block sits between free-running clock sources and a bank of clock outputs. For every output it decides, each reference clock cycle, whether the output toggles, is parked with its true leg low, or is released so that neither leg is driven. Outputs fall into three groups. CPU outputs are halted by a CPU stop pin. PCI outputs are halted by a PCI stop pin when their gating bit allows it. Request outputs are halted by their own clock-request pin. A power-down pin halts every group. Each output toggles at half the reference rate, so one output period lasts two reference cycles.

All stop pins pass through two-flop synchronisers before use. The control register arrives as parallel fields: a per-output enable, a per-PCI-output gating bit, a per-CPU-output stop mode and a per-group power-down mode. After power-good first rises, the configuration straps are latched once. Outputs then stay parked for a settling count measured in reference cycles before normal operation starts. A halt never cuts a high phase short. An output that is high finishes its pulse, goes low, and only then is it held.

Top module: `clk_stop_ctrl`

## Requirements
- R1: From reset until `outs_ready` is high, every output has true 0, complement 1 and drive 1, and its 2-bit state field reads stopped (00).
- R2: The first synchronised rise of `pwr_ok` copies `strap_i` into `strap_q`. Any later fall or rise of `pwr_ok` leaves `strap_q` and `outs_ready` unchanged.
- R3: `outs_ready` rises exactly SETTLE_CYC cycles after `strap_q` is loaded, and then stays high.
- R4: A running output (state 01) inverts its true leg on every cycle, keeps drive 1, and its complement equals the inverse of true.
- R5: A halt never holds the true leg high. A high output first goes low in a one-cycle stopping state (10), then moves to stopped (00). In the stopped state the true leg is 0.
- R6: While `cpu_stop_n` is low, CPU output i is stopped. With `cfg_cpu_stop_tri[i]`=1 it is released (drive 0, complement 0); with 0 it stays driven (drive 1, complement 1).
- R7: After `cpu_stop_n` rises, each enabled CPU output is back in state 01 within 4 reference cycles, which is two output periods.
- R8: While `pci_stop_n` is low, PCI output k stops driven low only if `cfg_pci_gate[k]`=1. Outputs with 0 keep running.
- R9: While `clk_req_n[j]` is high, request output j alone is stopped and released (drive 0, complement 0).
- R10: While `pwr_down_n` is low, every output is stopped. Each group is released when its `cfg_pd_tri` bit is 1 (bit 0 CPU, bit 1 PCI, bit 2 request) and is otherwise driven low.
- R11: `cfg_oe[i]`=0 stops output i whatever the stop pins are. CPU outputs are then released; PCI and request outputs stay driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Power-good, active high |
| strap_i | input | STRAP_W | Configuration straps |
| cpu_stop_n | input | 1 | CPU group stop, active low |
| pci_stop_n | input | 1 | PCI group stop, active low |
| clk_req_n | input | N_REQ | Per request output clock request, active low |
| pwr_down_n | input | 1 | Power down, active low |
| cfg_oe | input | N_OUT | Per-output enable (CPU, then PCI, then request) |
| cfg_pci_gate | input | N_PCI | 1 = PCI output obeys PCI stop |
| cfg_cpu_stop_tri | input | N_CPU | 1 = CPU output released while CPU stop is active |
| cfg_pd_tri | input | 3 | Per-group release during power down |
| strap_q | output | STRAP_W | Latched straps |
| outs_ready | output | 1 | Settling finished, normal operation |
| out_t | output | N_OUT | True leg of each output |
| out_c | output | N_OUT | Complement leg of each output |
| out_drv | output | N_OUT | 1 = output driven, 0 = high impedance |
| out_state | output | 2*N_OUT | Per-output state: 00 stopped, 01 running, 10 stopping |

## Verification
The assertions check the per-cycle properties on every output. A stopped output always sits low. The stopping state always follows a high level. A running output toggles every cycle, and its complement and drive legs agree with the true leg. Readiness is sticky, and the latched straps never move once outputs are live. Only the bench scenarios can show which pin or register bit stops which output, which drive mode each stop selects, the resume latency after CPU stop, the exact settling count, and that a second power-good pulse is ignored.

// File: rtl/csg_pkg.sv
package csg_pkg;
    typedef enum logic [1:0] {
        LN_STOPPED  = 2'b00,
        LN_RUNNING  = 2'b01,
        LN_STOPPING = 2'b10
    } lane_st_e;

    typedef enum logic [1:0] {
        SEQ_WAIT   = 2'b00,
        SEQ_SETTLE = 2'b01,
        SEQ_RUN    = 2'b10
    } seq_e;
endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            sync_q <= {W{RST_VAL}};
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/csg_seq.sv
module csg_seq
    import csg_pkg::*;
#(
    parameter int STRAP_W    = 4,
    parameter int SETTLE_CYC = 25773
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pg_s,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [STRAP_W-1:0] strap_q,
    output logic               ready
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_e               ph;
        logic [CW-1:0]      cnt;
        logic [STRAP_W-1:0] strap;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            SEQ_WAIT: begin
                if (pg_s) begin
                    s_d.ph    = SEQ_SETTLE;
                    s_d.cnt   = '0;
                    s_d.strap = strap_i;
                end
            end
            SEQ_SETTLE: begin
                if (s_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    s_d.ph = SEQ_RUN;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SEQ_RUN: s_d.ph = SEQ_RUN;
            default: s_d.ph = SEQ_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: SEQ_WAIT, cnt: '0, strap: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign strap_q = s_q.strap;
    assign ready   = (s_q.ph == SEQ_RUN);
endmodule

// File: rtl/csg_lane.sv
module csg_lane
    import csg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go,
    input  logic     park_tri,
    output logic     t,
    output logic     drv,
    output lane_st_e st
);
    typedef struct packed {
        lane_st_e st;
        logic     t;
        logic     drv;
    } lane_t;

    lane_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (go) begin
            l_d.t   = ~l_q.t;
            l_d.st  = LN_RUNNING;
            l_d.drv = 1'b1;
        end else if (l_q.t) begin
            l_d.t   = 1'b0;
            l_d.st  = LN_STOPPING;
            l_d.drv = 1'b1;
        end else begin
            l_d.t   = 1'b0;
            l_d.st  = LN_STOPPED;
            l_d.drv = ~park_tri;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '{st: LN_STOPPED, t: 1'b0, drv: 1'b1};
        end else begin
            l_q <= l_d;
        end
    end

    assign t   = l_q.t;
    assign drv = l_q.drv;
    assign st  = l_q.st;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import csg_pkg::*;
#(
    parameter int N_CPU      = 2,
    parameter int N_PCI      = 2,
    parameter int N_REQ      = 2,
    parameter int STRAP_W    = 4,
    parameter int SETTLE_CYC = 25773,
    localparam int N_OUT     = N_CPU + N_PCI + N_REQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic [N_REQ-1:0]   clk_req_n,
    input  logic               pwr_down_n,
    input  logic [N_OUT-1:0]   cfg_oe,
    input  logic [N_PCI-1:0]   cfg_pci_gate,
    input  logic [N_CPU-1:0]   cfg_cpu_stop_tri,
    input  logic [2:0]         cfg_pd_tri,
    output logic [STRAP_W-1:0] strap_q,
    output logic               outs_ready,
    output logic [N_OUT-1:0]   out_t,
    output logic [N_OUT-1:0]   out_c,
    output logic [N_OUT-1:0]   out_drv,
    output logic [2*N_OUT-1:0] out_state
);
    localparam int SW = 3 + N_REQ;

    logic [SW-1:0]    pins_s;
    logic             pg_s;
    logic             cpu_run_s, pci_run_s, pd_act;
    logic [N_REQ-1:0] req_s_n;

    csg_sync #(.W(SW), .RST_VAL(1'b1)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({clk_req_n, pwr_down_n, pci_stop_n, cpu_stop_n}),
        .dout (pins_s)
    );

    csg_sync #(.W(1), .RST_VAL(1'b0)) u_pg_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwr_ok),
        .dout (pg_s)
    );

    assign cpu_run_s = pins_s[0];
    assign pci_run_s = pins_s[1];
    assign pd_act    = ~pins_s[2];
    assign req_s_n   = pins_s[SW-1:3];

    csg_seq #(.STRAP_W(STRAP_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pg_s   (pg_s),
        .strap_i(strap_i),
        .strap_q(strap_q),
        .ready  (outs_ready)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
        logic     go, park_tri;
        lane_st_e st;

        if (i < N_CPU) begin : g_cpu
            assign go       = outs_ready & cfg_oe[i] & ~pd_act & cpu_run_s;
            assign park_tri = outs_ready & (pd_act ? cfg_pd_tri[0]
                                           : (~cfg_oe[i] | cfg_cpu_stop_tri[i]));
        end else if (i < N_CPU + N_PCI) begin : g_pci
            assign go       = outs_ready & cfg_oe[i] & ~pd_act
                              & (pci_run_s | ~cfg_pci_gate[i-N_CPU]);
            assign park_tri = outs_ready & pd_act & cfg_pd_tri[1];
        end else begin : g_req
            assign go       = outs_ready & cfg_oe[i] & ~pd_act
                              & ~req_s_n[i-N_CPU-N_PCI];
            assign park_tri = outs_ready & (pd_act ? cfg_pd_tri[2] : cfg_oe[i]);
        end

        csg_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .go      (go),
            .park_tri(park_tri),
            .t       (out_t[i]),
            .drv     (out_drv[i]),
            .st      (st)
        );

        assign out_c[i]           = out_drv[i] & ~out_t[i];
        assign out_state[2*i +: 2] = st;
    end
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
    parameter int N_OUT   = 6,
    parameter int STRAP_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               outs_ready,
    input logic [STRAP_W-1:0] strap_q,
    input logic [N_OUT-1:0]   out_t,
    input logic [N_OUT-1:0]   out_c,
    input logic [N_OUT-1:0]   out_drv,
    input logic [2*N_OUT-1:0] out_state
);
    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(outs_ready) |-> outs_ready);

    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(outs_ready) |-> $stable(strap_q));

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        a_r5_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
            (out_state[2*i +: 2] == 2'b00) |-> !out_t[i]);

        a_r5_stopping_after_high: assert property (@(posedge clk) disable iff (!rst_n)
            (out_state[2*i +: 2] == 2'b10) |-> (!out_t[i] && $past(out_t[i])));

        a_r4_run_toggles: assert property (@(posedge clk) disable iff (!rst_n)
            (out_state[2*i +: 2] == 2'b01 && $past(out_state[2*i +: 2]) == 2'b01)
            |-> (out_t[i] != $past(out_t[i])));

        a_r4_legs_agree: assert property (@(posedge clk) disable iff (!rst_n)
            out_drv[i] |-> (out_c[i] == !out_t[i]));

        a_r6_released_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !out_drv[i] |-> (!out_t[i] && !out_c[i] && out_state[2*i +: 2] == 2'b00));

        a_r1_parked_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
            !outs_ready |-> (out_state[2*i +: 2] == 2'b00 && out_drv[i]));
    end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_OUT(N_OUT), .STRAP_W(STRAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .outs_ready(outs_ready),
    .strap_q   (strap_q),
    .out_t     (out_t),
    .out_c     (out_c),
    .out_drv   (out_drv),
    .out_state (out_state)
);

// File: tb/sim_clk_stop_ctrl.sv
`timescale 1ns/1ps
module sim_clk_stop_ctrl;
    localparam int NC = 2, NP = 2, NR = 2, SWID = 4, SETTLE = 20;
    localparam int NO = NC + NP + NR;

    logic            clk = 1'b0;
    logic            rst_n, pwr_ok, cpu_stop_n, pci_stop_n, pwr_down_n;
    logic [SWID-1:0] strap_i, strap_q;
    logic [NR-1:0]   clk_req_n;
    logic [NO-1:0]   cfg_oe, out_t, out_c, out_drv;
    logic [NP-1:0]   cfg_pci_gate;
    logic [NC-1:0]   cfg_cpu_stop_tri;
    logic [2:0]      cfg_pd_tri;
    logic            outs_ready;
    logic [2*NO-1:0] out_state;

    always #10 clk = ~clk;

    clk_stop_ctrl #(.N_CPU(NC), .N_PCI(NP), .N_REQ(NR), .STRAP_W(SWID),
                    .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .strap_i(strap_i),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .clk_req_n(clk_req_n),
        .pwr_down_n(pwr_down_n), .cfg_oe(cfg_oe), .cfg_pci_gate(cfg_pci_gate),
        .cfg_cpu_stop_tri(cfg_cpu_stop_tri), .cfg_pd_tri(cfg_pd_tri),
        .strap_q(strap_q), .outs_ready(outs_ready), .out_t(out_t), .out_c(out_c),
        .out_drv(out_drv), .out_state(out_state)
    );

    typedef struct {
        string      tag;
        int         lane;
        bit         toggling;
        logic       t, c, drv;
        logic [1:0] st;
    } exp_t;

    exp_t sbq[$];
    bit   mon_busy = 1'b0;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // driver side: push expected lane conditions
    task automatic expect_static(input string tag, input int lane,
                                 input logic t, input logic c, input logic drv);
        exp_t e;
        e.tag = tag; e.lane = lane; e.toggling = 1'b0;
        e.t = t; e.c = c; e.drv = drv; e.st = 2'b00;
        sbq.push_back(e);
    endtask

    task automatic expect_run(input string tag, input int lane);
        exp_t e;
        e.tag = tag; e.lane = lane; e.toggling = 1'b1;
        e.t = 1'b0; e.c = 1'b0; e.drv = 1'b1; e.st = 2'b01;
        sbq.push_back(e);
    endtask

    task automatic drain;
        wait (sbq.size() == 0 && !mon_busy);
        @(negedge clk);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expectations and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                exp_t e;
                logic [3:0] got;
                mon_busy = 1'b1;
                e = sbq.pop_front();
                if (e.toggling) begin
                    logic t0;
                    t0 = out_t[e.lane];
                    @(negedge clk);
                    got = {out_state[2*e.lane +: 2], out_drv[e.lane], out_c[e.lane]};
                    chk(out_t[e.lane] != t0 && got == {2'b01, 1'b1, ~out_t[e.lane]},
                        $sformatf("%s lane%0d running", e.tag, e.lane),
                        $sformatf("t %b->%b st/drv/c=%b", t0, out_t[e.lane], got),
                        "toggle, st/drv/c=01 1 ~t");
                end else begin
                    got = {out_state[2*e.lane +: 2] == 2'b00, out_t[e.lane],
                           out_c[e.lane], out_drv[e.lane]};
                    chk(got == {1'b1, e.t, e.c, e.drv},
                        $sformatf("%s lane%0d parked", e.tag, e.lane),
                        $sformatf("stopped/t/c/drv=%b", got),
                        $sformatf("stopped/t/c/drv=1%b%b%b", e.t, e.c, e.drv));
                end
            end
            mon_busy = 1'b0;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int cnt;
        bit low_ok;
        rst_n = 1'b0; pwr_ok = 1'b0; strap_i = 4'hA;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; clk_req_n = '0; pwr_down_n = 1'b1;
        cfg_oe = '1; cfg_pci_gate = 2'b01; cfg_cpu_stop_tri = 2'b10; cfg_pd_tri = 3'b101;
        cyc(5);
        rst_n = 1'b1;
        cyc(3);

        // R1: parked before power-good
        for (int i = 0; i < NO; i++) expect_static("R1", i, 1'b0, 1'b1, 1'b1);
        drain();
        chk(outs_ready == 1'b0, "R1 ready low", $sformatf("%b", outs_ready), "0");
        cyc(10);
        chk(outs_ready == 1'b0, "R1 ready low without power-good",
            $sformatf("%b", outs_ready), "0");

        // R2, R3: strap latch and settling count
        pwr_ok = 1'b1;
        cnt = 0;
        while (strap_q != 4'hA && cnt < 10) begin @(negedge clk); cnt++; end
        chk(strap_q == 4'hA, "R2 strap latch", $sformatf("%h", strap_q), "a");
        chk(outs_ready == 1'b0, "R3 not ready at latch", $sformatf("%b", outs_ready), "0");
        cnt = 0;
        while (!outs_ready && cnt < 100) begin @(negedge clk); cnt++; end
        chk(cnt == SETTLE, "R3 settling count", $sformatf("%0d", cnt), $sformatf("%0d", SETTLE));

        // R4: all lanes running
        cyc(6);
        for (int i = 0; i < NO; i++) expect_run("R4", i);
        drain();

        // R6 and R5: CPU stop
        cpu_stop_n = 1'b0;
        low_ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (out_state[1:0] != 2'b01 && out_t[0]) low_ok = 1'b0;
        end
        chk(low_ok, "R5 stop never holds high", $sformatf("%b", low_ok), "1");
        expect_static("R6 driven", 0, 1'b0, 1'b1, 1'b1);
        expect_static("R6 released", 1, 1'b0, 1'b0, 1'b0);
        for (int i = NC; i < NO; i++) expect_run("R6 others", i);
        drain();

        // R7: resume latency
        cpu_stop_n = 1'b1;
        cnt = 0;
        while (out_state[1:0] != 2'b01 && cnt < 20) begin @(negedge clk); cnt++; end
        chk(cnt <= 4, "R7 resume cycles", $sformatf("%0d", cnt), "<=4");
        cyc(2);
        expect_run("R7", 1);
        drain();

        // R8: PCI gating
        pci_stop_n = 1'b0;
        cyc(8);
        expect_static("R8 gated", NC, 1'b0, 1'b1, 1'b1);
        expect_run("R8 free", NC + 1);
        expect_run("R8 cpu", 0);
        drain();
        pci_stop_n = 1'b1;
        cyc(6);
        expect_run("R8 back", NC);
        drain();

        // R9: clock request
        clk_req_n = 2'b10;
        cyc(8);
        expect_static("R9 released", NC + NP + 1, 1'b0, 1'b0, 1'b0);
        expect_run("R9 other", NC + NP);
        drain();
        clk_req_n = 2'b00;
        cyc(6);
        expect_run("R9 back", NC + NP + 1);
        drain();

        // R10: power down
        pwr_down_n = 1'b0;
        cyc(8);
        for (int i = 0; i < NC; i++) expect_static("R10 cpu", i, 1'b0, 1'b0, 1'b0);
        for (int i = NC; i < NC + NP; i++) expect_static("R10 pci", i, 1'b0, 1'b1, 1'b1);
        for (int i = NC + NP; i < NO; i++) expect_static("R10 req", i, 1'b0, 1'b0, 1'b0);
        drain();
        pwr_down_n = 1'b1;
        cyc(6);
        expect_run("R10 back", 0);
        drain();

        // R11: output enable
        cfg_oe = 6'b111010;
        cyc(8);
        expect_static("R11 cpu off", 0, 1'b0, 1'b0, 1'b0);
        expect_static("R11 pci off", NC, 1'b0, 1'b1, 1'b1);
        expect_run("R11 neighbour", 1);
        drain();
        cfg_oe = '1;
        cyc(6);

        // R2: second power-good pulse ignored
        pwr_ok = 1'b0;
        strap_i = 4'h5;
        cyc(5);
        pwr_ok = 1'b1;
        cyc(10);
        chk(strap_q == 4'hA, "R2 strap held", $sformatf("%h", strap_q), "a");
        chk(outs_ready == 1'b1, "R2 ready held", $sformatf("%b", outs_ready), "1");
        expect_run("R2 still running", 0);
        drain();

        done = 1'b1;
        report();
    end
endmodule